// File: doc/BRIEF.md
# I2C 512-Byte Memory Target

This block is an I2C target that serves a memory of 512 bytes. The master addresses it with one device byte. That byte holds a fixed 4-bit type code (`1010`), two select bits that must equal the `strap_sel` inputs, the most significant memory address bit, and the read/write flag. Only the low eight address bits travel in a separate byte. Written data is stored at the address pointer, and the pointer advances after each byte, wrapping from 1FFh to 000h.

There are two ways to read. A random read first sets the address with a write phase, then sends a repeated start and a read device byte. A current-address read skips the address phase. It continues from the address that the last completed transfer touched. The upper bit of that address comes from the device byte just received, so the master can point a current read at either half of the memory. That 9-bit last-access register is loaded only when a stop condition closes a transfer. It has no defined value at power-up.

The bus lines are sampled in the system clock domain. SDA is driven only through a pull-low enable for an external open-drain pad.

Top module: `i2c_mem512_target`

## Requirements
- R1: After reset the SDA pull-low enable is inactive, and it stays inactive while the target is idle.
- R2: The target acknowledges a device byte only when its upper nibble is binary 1010 and bits 3:2 equal `strap_sel`. On a mismatch it does not acknowledge and never pulls SDA until the next start.
- R3: In a write, the byte after the device byte sets the pointer to {bit 1 of the device byte, that byte}. Each later byte is stored at the pointer, and the pointer then increments modulo 512.
- R4: A random read returns the byte at the address set by the preceding write phase, after a repeated start and a read device byte (bit 0 = 1).
- R5: While the master acknowledges a read byte, the target sends the byte at the next address, wrapping from 1FFh to 000h. A master NACK ends the read.
- R6: A current-address read returns the byte at n+1 modulo 512, where n is {bit 1 of the device byte, low 8 bits of the last-access register}.
- R7: The last-access register takes the address of the last byte written, read, or addressed in a transfer, and only when a stop condition ends that transfer. A transfer that sets only the address also updates it.
- R8: The SDA pull-low enable changes only while the synchronized SCL is low, or when a start or stop releases it.
- R9: A start condition at any point abandons the transfer in progress. A partly received byte is discarded, and the target waits for a device byte.
- R10: Bytes move MSB first. The acknowledge is a low SDA during the ninth SCL pulse, and read data bits are placed on SDA after SCL falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| strap_sel | input | 2 | Pin-strapped select bits compared with device byte bits 3:2 |
| sda_pull_o | output | 1 | High to pull SDA low through the open-drain pad |

## Verification
The hardest situation to reach is one where the upper address bit supplied by a current-address read differs from the upper bit of the stored last-access address. Reaching it also requires that the stored address was committed by a stop and not by an abandoned transfer. The bench first fills the whole memory with an arithmetic pattern in one wrapping burst. It then chains current reads whose device bytes alternate the upper bit, so each expected address follows from the previous read. A transfer cut short by a repeated start checks that the partly received byte never reaches the memory.

// File: rtl/i2c_mem512_pkg.sv
`timescale 1ns/1ps
package i2c_mem512_pkg;

   localparam logic [3:0] TYPE_CODE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RMACK
   } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain[g] <= 1'b1;
               sda_chain[g] <= 1'b1;
            end else begin
               scl_chain[g] <= scl_i;
               sda_chain[g] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain[g] <= 1'b1;
               sda_chain[g] <= 1'b1;
            end else begin
               scl_chain[g] <= scl_chain[g-1];
               sda_chain[g] <= sda_chain[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_s    = scl_chain[STAGES-1];
   assign sda_s    = sda_chain[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_ram.sv
`timescale 1ns/1ps
module i2c_byte_ram #(
   parameter int unsigned AW = 9,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      rdata <= cells[raddr];
   end

endmodule

// File: rtl/i2c_target_ctrl.sv
`timescale 1ns/1ps
module i2c_target_ctrl
   import i2c_mem512_pkg::*;
#(
   parameter int unsigned AW = 9,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_ev,
   input  logic          stop_ev,
   input  logic [1:0]    strap_sel,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   output logic [AW-1:0] mem_raddr,
   output logic          sda_pull,
   output tgt_state_e    state_o,
   output logic [AW-1:0] last_buf_o
);

   localparam int unsigned CW = $clog2(DW);
   localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

   tgt_state_e    st;
   logic [DW-1:0] shreg;
   logic [CW-1:0] bitcnt;
   logic          byte_done;
   logic          rd_mode;
   logic          hi_bit;
   logic          addr_set;
   logic          more;
   logic          pend;
   logic [AW-1:0] ptr;
   logic [AW-1:0] last_acc;
   logic [AW-1:0] last_buf;
   logic          dev_match;

   assign dev_match  = (shreg[7:4] == TYPE_CODE) && (shreg[3:2] == strap_sel);
   assign mem_raddr  = ptr;
   assign state_o    = st;
   assign last_buf_o = last_buf;

   // last-access register: no reset value, loaded only at a stop
   always_ff @(posedge clk) begin
      if (stop_ev && pend) begin
         last_buf <= last_acc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         shreg     <= '0;
         bitcnt    <= '0;
         byte_done <= 1'b0;
         rd_mode   <= 1'b0;
         hi_bit    <= 1'b0;
         addr_set  <= 1'b0;
         more      <= 1'b0;
         pend      <= 1'b0;
         ptr       <= '0;
         last_acc  <= '0;
         sda_pull  <= 1'b0;
         mem_we    <= 1'b0;
         mem_waddr <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         if (start_ev) begin
            st        <= ST_DEV;
            sda_pull  <= 1'b0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
         end else if (stop_ev) begin
            st        <= ST_IDLE;
            sda_pull  <= 1'b0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            pend      <= 1'b0;
            addr_set  <= 1'b0;
         end else begin
            case (st)
               ST_DEV, ST_ADDR, ST_WDATA: begin
                  if (scl_rise && !byte_done) begin
                     shreg <= {shreg[DW-2:0], sda_s};
                     if (bitcnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end else if (scl_fall && byte_done) begin
                     byte_done <= 1'b0;
                     bitcnt    <= '0;
                     if (st == ST_DEV) begin
                        if (dev_match) begin
                           sda_pull <= 1'b1;
                           hi_bit   <= shreg[1];
                           rd_mode  <= shreg[0];
                           st       <= ST_DEV_ACK;
                           if (shreg[0] && !addr_set) begin
                              ptr <= {shreg[1], last_buf[AW-2:0]} + 1'b1;
                           end
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (st == ST_ADDR) begin
                        ptr      <= {hi_bit, shreg};
                        last_acc <= {hi_bit, shreg};
                        pend     <= 1'b1;
                        addr_set <= 1'b1;
                        sda_pull <= 1'b1;
                        st       <= ST_ADDR_ACK;
                     end else begin
                        mem_we    <= 1'b1;
                        mem_waddr <= ptr;
                        mem_wdata <= shreg;
                        last_acc  <= ptr;
                        ptr       <= ptr + 1'b1;
                        pend      <= 1'b1;
                        sda_pull  <= 1'b1;
                        st        <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        shreg    <= mem_rdata;
                        sda_pull <= ~mem_rdata[DW-1];
                        last_acc <= ptr;
                        ptr      <= ptr + 1'b1;
                        pend     <= 1'b1;
                        bitcnt   <= '0;
                        st       <= ST_RDATA;
                     end else begin
                        sda_pull <= 1'b0;
                        st       <= ST_ADDR;
                     end
                  end
               end
               ST_ADDR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     st       <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_pull <= 1'b0;
                        st       <= ST_RMACK;
                     end else begin
                        bitcnt   <= bitcnt + 1'b1;
                        shreg    <= {shreg[DW-2:0], 1'b0};
                        sda_pull <= ~shreg[DW-2];
                     end
                  end
               end
               ST_RMACK: begin
                  if (scl_rise) begin
                     more <= ~sda_s;
                  end else if (scl_fall) begin
                     if (more) begin
                        shreg    <= mem_rdata;
                        sda_pull <= ~mem_rdata[DW-1];
                        last_acc <= ptr;
                        ptr      <= ptr + 1'b1;
                        pend     <= 1'b1;
                        bitcnt   <= '0;
                        st       <= ST_RDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_pull <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_mem512_target.sv
`timescale 1ns/1ps
module i2c_mem512_target
   import i2c_mem512_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_sel,
   output logic       sda_pull_o
);

   if (DW != 8) begin : g_bad_dw
      $error("i2c_mem512_target: device byte layout needs DW == 8");
   end
   if (AW != DW + 1) begin : g_bad_aw
      $error("i2c_mem512_target: AW must be DW + 1");
   end

   logic          scl_s;
   logic          sda_s;
   logic          scl_rise;
   logic          scl_fall;
   logic          start_ev;
   logic          stop_ev;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [DW-1:0] mem_wdata;
   logic [AW-1:0] mem_raddr;
   logic [DW-1:0] mem_rdata;
   tgt_state_e    ctl_state;
   logic [AW-1:0] addr_buf;

   i2c_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2c_target_ctrl #(
      .AW (AW),
      .DW (DW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_ev   (start_ev),
      .stop_ev    (stop_ev),
      .strap_sel  (strap_sel),
      .mem_rdata  (mem_rdata),
      .mem_we     (mem_we),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata),
      .mem_raddr  (mem_raddr),
      .sda_pull   (sda_pull_o),
      .state_o    (ctl_state),
      .last_buf_o (addr_buf)
   );

   i2c_byte_ram #(
      .AW (AW),
      .DW (DW)
   ) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

endmodule

// File: rtl/i2c_mem512_target_chk.sv
`timescale 1ns/1ps
module i2c_mem512_target_chk
   import i2c_mem512_pkg::*;
#(
   parameter int unsigned AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          start_ev,
   input logic          stop_ev,
   input logic          pull,
   input tgt_state_e    state,
   input logic [AW-1:0] abuf
);

   a_r8_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pull != $past(pull)) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

   a_r9_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state == ST_DEV && !pull));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !pull);

   a_r10_pull_slots: assert property (@(posedge clk) disable iff (!rst_n)
      pull |-> (state inside {ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

   a_r7_buf_only_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_ev |=> $stable(abuf));

   a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ev && !start_ev) |=> (state == ST_IDLE));

endmodule

bind i2c_mem512_target i2c_mem512_target_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .start_ev (start_ev),
   .stop_ev  (stop_ev),
   .pull     (sda_pull_o),
   .state    (ctl_state),
   .abuf     (addr_buf)
);

// File: tb/i2c_mem512_target_tb.sv
`timescale 1ns/1ps
module i2c_mem512_target_tb;

   localparam int Q = 3;
   localparam logic [1:0] STRAP = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic pull;
   logic sda;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   assign sda = sda_m & ~pull;

   i2c_mem512_target u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda),
      .strap_sel  (STRAP),
      .sda_pull_o (pull)
   );

   function automatic logic [7:0] pat(input int a);
      int v;
      v = (a * 37 + 11) ^ (a >> 3);
      return v[7:0];
   endfunction

   function automatic logic [7:0] dev(input logic a8, input logic rd);
      return {4'b1010, STRAP, a8, rd};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(2*Q);
      sda_m = 1'b0; tick(2*Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl = 1'b1;   tick(2*Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic clk_bit(input logic b, output logic r);
      sda_m = b; tick(Q);
      scl = 1'b1; tick(Q);
      r = sda;    tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
      clk_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic mack);
      logic r;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, r);
         d = {d[6:0], r};
      end
      clk_bit(~mack, r);
   endtask

   task automatic cur_read(input logic a8, output logic [7:0] d);
      logic ack;
      bus_start();
      send_byte(dev(a8, 1'b1), ack);
      check(ack, "R2 current-read device ack", ack, 1);
      recv_byte(d, 1'b0);
      bus_stop();
   endtask

   task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
      logic ack;
      bus_start();
      send_byte(dev(a[8], 1'b0), ack);
      check(ack, "R2 device ack", ack, 1);
      send_byte(a[7:0], ack);
      check(ack, "R3 address ack", ack, 1);
      bus_start();
      send_byte(dev(a[8], 1'b1), ack);
      check(ack, "R4 read device ack", ack, 1);
      recv_byte(d, 1'b0);
      bus_stop();
   endtask

   initial begin
      logic       ack;
      logic [7:0] d;
      int         nacks;
      int         bad;

      tick(10);
      check(pull == 1'b0 && sda == 1'b1, "R1 reset release", pull, 0);
      rst_n = 1'b1;
      tick(10);
      check(pull == 1'b0, "R1 idle after reset", pull, 0);

      // R3 R10: fill memory in one burst starting at 100h, wrapping past 1FFh
      bus_start();
      send_byte(dev(1'b1, 1'b0), ack);
      check(ack, "R2 write device ack", ack, 1);
      send_byte(8'h00, ack);
      check(ack, "R3 address ack", ack, 1);
      nacks = 0;
      for (int i = 0; i < 512; i++) begin
         send_byte(pat((256 + i) % 512), ack);
         if (!ack) nacks++;
      end
      check(nacks == 0, "R3 data acks", nacks, 0);
      bus_stop();

      // R6 R7: last written 0FFh; the upper bit comes from each device byte
      cur_read(1'b0, d);
      check(d == pat(256), "R6 current read after burst", d, pat(256));
      cur_read(1'b1, d);
      check(d == pat(257), "R6 upper bit from device byte", d, pat(257));
      cur_read(1'b0, d);
      check(d == pat(2), "R6 upper bit cleared", d, pat(2));

      // R4 random reads
      rand_read(9'h16F, d);
      check(d == pat(9'h16F), "R4 random 16Fh", d, pat(9'h16F));
      cur_read(1'b1, d);
      check(d == pat(9'h170), "R6 follows random read", d, pat(9'h170));
      rand_read(9'h000, d);
      check(d == pat(0), "R4 random 000h", d, pat(0));
      rand_read(9'h0FF, d);
      check(d == pat(9'h0FF), "R4 random 0FFh", d, pat(9'h0FF));
      rand_read(9'h1FF, d);
      check(d == pat(9'h1FF), "R4 random 1FFh", d, pat(9'h1FF));
      cur_read(1'b1, d);
      check(d == pat(0), "R6 wrap 1FFh to 000h", d, pat(0));

      // R5 sequential read of whole memory
      bus_start();
      send_byte(dev(1'b0, 1'b0), ack);
      send_byte(8'h00, ack);
      bus_start();
      send_byte(dev(1'b0, 1'b1), ack);
      check(ack, "R4 read device ack", ack, 1);
      bad = 0;
      for (int i = 0; i < 512; i++) begin
         recv_byte(d, i != 511);
         if (d != pat(i)) begin
            bad++;
            if (bad < 4) check(1'b0, "R5 sequential byte", d, pat(i));
         end
      end
      check(bad == 0, "R5 sequential sweep", bad, 0);
      bus_stop();
      cur_read(1'b1, d);
      check(d == pat(0), "R6 wrap after sequential", d, pat(0));

      // R2: wrong type code and wrong strap are ignored
      bus_start();
      send_byte({4'b1011, STRAP, 2'b01}, ack);
      check(!ack, "R2 wrong type nack", ack, 0);
      send_byte(8'h00, ack);
      check(!ack, "R2 quiet after mismatch", ack, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1010, ~STRAP, 2'b01}, ack);
      check(!ack, "R2 wrong strap nack", ack, 0);
      bus_stop();
      cur_read(1'b0, d);
      check(d == pat(1), "R7 buffer kept across mismatch", d, pat(1));

      // R7: address-only write sets the buffer
      bus_start();
      send_byte(dev(1'b1, 1'b0), ack);
      send_byte(8'h23, ack);
      bus_stop();
      cur_read(1'b1, d);
      check(d == pat(9'h124), "R7 address-only write", d, pat(9'h124));

      // R9: partial byte aborted by a repeated start is not stored
      bus_start();
      send_byte(dev(1'b0, 1'b0), ack);
      send_byte(8'h40, ack);
      clk_bit(1'b0, ack);
      clk_bit(1'b0, ack);
      clk_bit(1'b0, ack);
      bus_start();
      send_byte(dev(1'b0, 1'b1), ack);
      check(ack, "R9 device ack after abort", ack, 1);
      recv_byte(d, 1'b0);
      bus_stop();
      check(d == pat(9'h040), "R9 aborted byte discarded", d, pat(9'h040));

      // R3 R5: write wraps 1FFh -> 000h, read back across the wrap
      bus_start();
      send_byte(dev(1'b1, 1'b0), ack);
      send_byte(8'hFF, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      send_byte(8'h33, ack);
      check(ack, "R3 wrap write ack", ack, 1);
      bus_stop();
      bus_start();
      send_byte(dev(1'b1, 1'b0), ack);
      send_byte(8'hFF, ack);
      bus_start();
      send_byte(dev(1'b1, 1'b1), ack);
      recv_byte(d, 1'b1);
      check(d == 8'h11, "R3 byte at 1FFh", d, 8'h11);
      recv_byte(d, 1'b1);
      check(d == 8'h22, "R5 read wraps to 000h", d, 8'h22);
      recv_byte(d, 1'b0);
      check(d == 8'h33, "R3 byte at 001h", d, 8'h33);
      bus_stop();
      tick(4);
      check(pull == 1'b0, "R1 released after stop", pull, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule